// File: doc/BRIEF.md
# S/PDIF Subframe Biphase-Mark Transmitter

This block turns a stream of 16-bit PCM samples into a consumer digital-audio line signal on one output pin. Samples arrive over a valid/ready handshake and alternate left, right, left, and so on. Each sample fills one 32-slot subframe. The subframe begins with a 4-slot sync pattern and carries the audio word in the middle slots. It closes with an even-parity bit. The slots are biphase-mark coded onto the line one half-cell at a time.

A clock enable paces the block at twice the bit rate. At 44.1 kHz that is 5.6448 MHz, or 128 half-cells per stereo frame. The block keeps no other timebase. A frame counter spans a 192-frame block. It chooses which of three sync patterns opens each subframe. The sync pattern is inverted whenever the line is high before it, so that every cell boundary still carries an edge.

A one-entry holding register separates the handshake from the line timing. If no sample is waiting when a subframe must begin, the block sends silence and reports an underrun.

Top module: `spdif_tx`

## Requirements
- R1: A synchronous active-high reset drives the line low and raises the ready output. It clears the frame counter, so the first subframe after reset is a left subframe that carries the block-start sync pattern.
- R2: The line changes only on a clock edge where the half-cell enable is high. Each subframe lasts exactly 64 enabled half-cells.
- R3: Slots 4 to 31 are biphase-mark coded. The line toggles at the start of every slot and toggles again mid-slot only when the slot bit is 1.
- R4: Slots 0 to 3 carry an 8-half-cell sync pattern, sent first half-cell first. Written for a low line before the pattern, it is 11101000 for block start, 11100010 for any other left subframe and 11100100 for a right subframe. When the line is high before the pattern, the bitwise inverse is sent.
- R5: Subframes alternate left then right, starting with left. The block-start pattern opens the left subframe of frame 0 and of every 192nd frame after it. All other left subframes use the ordinary left pattern.
- R6: Slots are sent in ascending order. Slots 4 to 11 are 0. Sample bit 0 sits in slot 12 and sample bit 15 in slot 27. Slots 28, 29 and 30 (validity, user, status) are 0.
- R7: Slot 31 is set so that slots 4 through 31 together hold an even number of ones.
- R8: The ready output is high exactly when the holding register is empty. A sample is taken on a clock edge where valid and ready are both high. The held sample is used, and the register emptied, on the edge where a subframe begins.
- R9: If the holding register is empty when a subframe begins, that subframe carries a zero sample and the underrun output is high for exactly the following cycle. A sample accepted on that same edge is kept for the next subframe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hc_en | input | 1 | Half-cell enable, high once per half-cell period (twice the bit rate) |
| smp_valid | input | 1 | Upstream sample is valid |
| smp_ready | output | 1 | Holding register is empty and can take a sample |
| smp_data | input | 16 | PCM sample, two's complement, in left/right order |
| line_out | output | 1 | Biphase-mark coded line signal |
| underrun | output | 1 | One-cycle pulse: a subframe began with no sample waiting |

## Verification
Two events can fall on the same edge: the start of a subframe, which empties the holding register, and the acceptance of a new sample. The bench provokes this collision in two ways. It drives a random half-cell enable against sparse random valids, and it also drives dense random valids. It judges the result from a bench model of the one-entry register. When the collision happens, the subframe on the line must carry zero. The underrun pulse must appear in the next cycle. The accepted sample must come out, bit-exact, in the subframe after that. A second coincidence is the block-start pattern landing on a subframe after a frame-counter wrap. To check it, the run is long enough to pass frame 192, and the decoded sync patterns are compared against the subframe index.

// File: rtl/spdif_pkg.sv
package spdif_pkg;

  localparam int SUB_SLOTS  = 32;
  localparam int HC_PER_SUB = 2 * SUB_SLOTS;
  localparam int SYNC_HC    = 8;
  localparam int HC_IDX_W   = $clog2(HC_PER_SUB);

  typedef enum logic [1:0] {
    SYNC_BLOCK,
    SYNC_LEFT,
    SYNC_RIGHT
  } sync_kind_t;

  // Half-cell patterns for a low line ahead of the sync field, MSB sent first.
  function automatic logic [SYNC_HC-1:0] sync_pattern(input sync_kind_t kind);
    case (kind)
      SYNC_BLOCK: return 8'b1110_1000;
      SYNC_LEFT:  return 8'b1110_0010;
      default:    return 8'b1110_0100;
    endcase
  endfunction

endpackage

// File: rtl/spdif_sample_hold.sv
module spdif_sample_hold #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                in_ready,
  input  logic                take,
  output logic                full,
  output logic [SAMPLE_W-1:0] data
);

  // Emptying on take happens first; a write in the same edge then refills.
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (take) full <= 1'b0;
      if (in_valid && !full) begin
        full <= 1'b1;
        data <= in_data;
      end
    end
  end

  assign in_ready = !full;

endmodule

// File: rtl/spdif_frame_seq.sv
module spdif_frame_seq
  import spdif_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sub_end,
  output sync_kind_t kind
);

  localparam int FC_W = $clog2(FRAMES_PER_BLOCK);
  localparam logic [FC_W-1:0] FC_LAST = FC_W'(FRAMES_PER_BLOCK - 1);

  logic [FC_W-1:0] frame_q;
  logic            right_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      right_q <= 1'b0;
    end else if (sub_end) begin
      right_q <= !right_q;
      if (right_q) frame_q <= (frame_q == FC_LAST) ? '0 : frame_q + 1'b1;
    end
  end

  always_comb begin
    if (right_q)             kind = SYNC_RIGHT;
    else if (frame_q == '0)  kind = SYNC_BLOCK;
    else                     kind = SYNC_LEFT;
  end

endmodule

// File: rtl/spdif_bmc_line.sv
module spdif_bmc_line
  import spdif_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hc_en,
  input  logic [SUB_SLOTS-1:0] slots_in,
  input  logic [SYNC_HC-1:0]   sync_in,
  output logic                 line_out,
  output logic [HC_IDX_W-1:0]  hc_idx,
  output logic                 sub_start,
  output logic                 sub_end
);

  logic [SUB_SLOTS-1:0] slots_q;
  logic [SYNC_HC-1:0]   sync_q;
  logic                 inv_q;

  assign sub_start = hc_en && (hc_idx == '0);
  assign sub_end   = hc_en && (hc_idx == HC_IDX_W'(HC_PER_SUB - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hc_idx   <= '0;
      line_out <= 1'b0;
      slots_q  <= '0;
      sync_q   <= '0;
      inv_q    <= 1'b0;
    end else if (hc_en) begin
      hc_idx <= hc_idx + 1'b1;
      if (hc_idx == '0) begin
        slots_q  <= slots_in;
        sync_q   <= sync_in;
        inv_q    <= line_out;
        line_out <= sync_in[SYNC_HC-1] ^ line_out;
      end else if (hc_idx < HC_IDX_W'(SYNC_HC)) begin
        line_out <= sync_q[3'd7 - hc_idx[2:0]] ^ inv_q;
      end else if (!hc_idx[0]) begin
        line_out <= !line_out;
      end else if (slots_q[hc_idx[HC_IDX_W-1:1]]) begin
        line_out <= !line_out;
      end
    end
  end

endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
  import spdif_pkg::*;
#(
  parameter int SAMPLE_W         = 16,
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hc_en,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                line_out,
  output logic                underrun
);

  localparam int AUDIO_MSB  = 27;
  localparam int PARITY_BIT = SUB_SLOTS - 1;

  logic                hold_full;
  logic [SAMPLE_W-1:0] hold_data;
  logic [SAMPLE_W-1:0] smp_sel;
  logic [SUB_SLOTS-1:0] slots;
  sync_kind_t          kind;
  logic [HC_IDX_W-1:0] hc_idx;
  logic                sub_start;
  logic                sub_end;

  spdif_sample_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .in_valid(smp_valid),
    .in_data (smp_data),
    .in_ready(smp_ready),
    .take    (sub_start),
    .full    (hold_full),
    .data    (hold_data)
  );

  spdif_frame_seq #(.FRAMES_PER_BLOCK(FRAMES_PER_BLOCK)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .sub_end(sub_end),
    .kind   (kind)
  );

  assign smp_sel = hold_full ? hold_data : '0;

  always_comb begin
    slots = '0;
    slots[AUDIO_MSB -: SAMPLE_W] = smp_sel;
    slots[PARITY_BIT] = ^slots[PARITY_BIT-1:4];
  end

  spdif_bmc_line u_line (
    .clk      (clk),
    .rst      (rst),
    .hc_en    (hc_en),
    .slots_in (slots),
    .sync_in  (sync_pattern(kind)),
    .line_out (line_out),
    .hc_idx   (hc_idx),
    .sub_start(sub_start),
    .sub_end  (sub_end)
  );

  always_ff @(posedge clk) begin
    if (rst) underrun <= 1'b0;
    else     underrun <= sub_start && !hold_full;
  end

endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk
  import spdif_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                hc_en,
  input logic                smp_valid,
  input logic                smp_ready,
  input logic                line_out,
  input logic                underrun,
  input logic [HC_IDX_W-1:0] hc_idx
);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!line_out && smp_ready));

  p_line_holds_r2: assert property (@(posedge clk) disable iff (rst)
    !hc_en |=> $stable(line_out));

  p_cell_edge_r3: assert property (@(posedge clk) disable iff (rst)
    (hc_en && hc_idx >= HC_IDX_W'(SYNC_HC) && !hc_idx[0]) |=> (line_out != $past(line_out)));

  p_accept_fills_r8: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_ready) |=> !smp_ready);

  p_underrun_empty_r9: assert property (@(posedge clk) disable iff (rst)
    underrun |-> $past(smp_ready));

  p_underrun_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    underrun |=> !underrun);

endmodule

bind spdif_tx spdif_tx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .hc_en    (hc_en),
  .smp_valid(smp_valid),
  .smp_ready(smp_ready),
  .line_out (line_out),
  .underrun (underrun),
  .hc_idx   (hc_idx)
);

// File: tb/spdif_tx_tb.sv
module spdif_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_SUB      = 400;

  logic        clk = 1'b0;
  logic        rst;
  logic        hc_en;
  logic        smp_valid;
  logic        smp_ready;
  logic [15:0] smp_data;
  logic        line_out;
  logic        underrun;

  spdif_tx u_dut (
    .clk      (clk),
    .rst      (rst),
    .hc_en    (hc_en),
    .smp_valid(smp_valid),
    .smp_ready(smp_ready),
    .smp_data (smp_data),
    .line_out (line_out),
    .underrun (underrun)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;
  bit          m_full;
  logic [15:0] m_data;
  logic [15:0] exp_smp [0:1023];
  int          n_start, n_dec, pulse, hc_pos, acc, vprob, n_block;
  bit          exp_un, last_en, last_line, prev_lvl, have_last;
  bit          cells [0:63];
  int          dirv [6] = '{16'hFFFF, 16'h8000, 16'h0001, 16'h0000, 16'h7FFF, 16'hAAAA};

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] exp_sync(input int n);
    if (n % 2 == 1)            return 8'b1110_0100;
    else if ((n/2) % 192 == 0) return 8'b1110_1000;
    else                       return 8'b1110_0010;
  endfunction

  task automatic decode_sub();
    logic [7:0]  got_sync, want;
    logic [31:0] bits;
    bit          lvl;
    int          bmc_err;
    for (int i = 0; i < 8; i++) got_sync[7-i] = cells[i];
    want = exp_sync(n_dec) ^ {8{prev_lvl}};
    if (n_dec % 2 == 0 && (n_dec/2) % 192 == 0) begin
      n_block++;
      chk(got_sync == want, "R5", "block-start sync", got_sync, want);
    end else begin
      chk(got_sync == want, "R4", "sync pattern", got_sync, want);
    end
    bits = '0;
    bmc_err = 0;
    lvl = cells[7];
    for (int s = 4; s < 32; s++) begin
      if (cells[2*s] == lvl) bmc_err++;
      bits[s] = cells[2*s] ^ cells[2*s+1];
      lvl = cells[2*s+1];
    end
    chk(bmc_err == 0, "R3", "missing cell-start edges", bmc_err, 0);
    chk(bits[27:12] == exp_smp[n_dec], "R6", "audio field", bits[27:12], exp_smp[n_dec]);
    chk(bits[11:4] == 8'h00 && bits[30:28] == 3'b000, "R6", "zero slots",
        {bits[30:28], bits[11:4]}, 0);
    chk(^bits[31:4] == 1'b0, "R7", "parity over slots 4-31", bits[31], ^bits[30:4]);
    prev_lvl = cells[63];
    n_dec++;
  endtask

  task automatic model_reset();
    m_full = 0; m_data = '0; n_start = 0; n_dec = 0; pulse = 0; hc_pos = 0;
    exp_un = 0; last_en = 0; prev_lvl = 0; have_last = 0;
  endtask

  task automatic step();
    bit rdy;
    @(negedge clk);
    if (last_en) begin
      cells[hc_pos] = line_out;
      hc_pos++;
      if (hc_pos == 64) begin
        decode_sub();
        hc_pos = 0;
      end
    end else if (have_last) begin
      chk(line_out == last_line, "R2", "line moved without enable", line_out, last_line);
    end
    last_line = line_out;
    have_last = 1;
    if (exp_un || underrun) chk(underrun == exp_un, "R9", "underrun pulse", underrun, exp_un);
    chk(smp_ready == !m_full, "R8", "ready vs hold state", smp_ready, !m_full);
    hc_en     = ($urandom_range(2) != 0);
    smp_valid = ($urandom_range(99) < vprob);
    smp_data  = (acc < 6) ? 16'(dirv[acc]) : 16'($urandom);
    rdy = !m_full;
    exp_un = 0;
    if (hc_en && pulse % 64 == 0) begin
      exp_smp[n_start] = m_full ? m_data : 16'h0000;
      exp_un = !m_full;
      m_full = 0;
      n_start++;
    end
    if (smp_valid && rdy) begin
      m_full = 1;
      m_data = smp_data;
      acc++;
    end
    if (hc_en) pulse++;
    last_en = hc_en;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; hc_en = 0; smp_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    model_reset();
    chk(line_out == 1'b0, "R1", "line after reset", line_out, 0);
    chk(smp_ready == 1'b1, "R1", "ready after reset", smp_ready, 1);
    chk(underrun == 1'b0, "R1", "underrun after reset", underrun, 0);
    last_line = line_out;
    have_last = 1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1; hc_en = 0; smp_valid = 0; smp_data = '0;
    acc = 0; n_block = 0; vprob = 75;
    model_reset();
    repeat (3) @(negedge clk);
    do_reset();
    // Short run, then a reset in the middle of a subframe.
    while (pulse < 12*64 + 30) step();
    do_reset();
    // Sparse samples: frequent underruns colliding with acceptances.
    vprob = 2;
    while (n_dec < 60) step();
    // Dense samples through a full 192-frame block wrap.
    vprob = 80;
    while (n_dec < N_SUB) step();
    chk(n_block >= 2, "R5", "block starts seen", n_block, 2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d subframes expected %0d", n_dec, N_SUB);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule